// File: doc/BRIEF.md
# Selective-Toggle Boundary Scan Output Chain

This block is a chain of boundary scan output cells for a test-access-port-controlled device. Every cell pairs a shift stage with an update latch. Under the external-test instruction, each pin drives the level held in its update latch. Under the selective-toggle instruction, the two storage elements are given different jobs. The update latch keeps the steady hold level that was loaded earlier under external test. The shift stage holds a selection pattern instead, and a 1 in that stage makes the pin follow a shared, slowly divided toggle clock. Toggling only happens while the controller sits in Run-Test/Idle. As soon as the controller leaves that state, every pin falls back to its hold level.

Besides the single-ended pins, the chain carries differential pair cells and two control cells. One control cell holds a common output enable for external test. The other holds a balance bit that sets how a selected pair toggles. In balanced mode the two legs toggle in opposite phase. In unbalanced mode the data stays fixed and only the driver enable toggles, so a capacitive sensor sees a non-zero sum. The enclosing controller supplies the capture, shift and update strobes, the instruction decode and the Run-Test/Idle indication. It also supplies the toggle clock, which must already be synchronous to the scan clock.

Top module: `stog_bscan_chain`

## Requirements
- R1: While reset is low, every shift stage and update latch clears: scan_out, pin_data, pin_en, diff_p and diff_en are 0, and diff_n is 1.
- R2: With shift_dr high and capture_dr low, the chain moves one place per clock. The order from scan_in to scan_out is: the enable control cell (position 0), pin cells 0 to N_PINS-1 (positions 1 to N_PINS), pair cells 0 to N_DIFF-1 (the next N_DIFF positions), and last the balance control cell. scan_out is the balance cell's shift stage.
- R3: A clock with capture_dr high loads pin_in into the pin cells' shift stages and diff_in into the pair cells' shift stages. Each control cell reloads its own update latch value. Capture takes priority over shift.
- R4: A clock with update_dr high and mode_stog low copies every shift stage into its update latch.
- R5: While mode_stog is high, update_dr is ignored and every update latch keeps its value.
- R6: With mode_extest high and mode_stog low, pin_data[i] equals pin i's update latch and every pin_en equals the enable control latch. diff_p equals the pair's latch, diff_n is its inverse, and diff_en equals the enable control latch.
- R7: With mode_stog and run_idle both high, a pin whose shift stage is 1 drives tog_clk on pin_data. A pin whose shift stage is 0 drives its update latch value.
- R8: With mode_stog high and run_idle low, every pin and pair drives its update latch value, as under R6. The change takes effect in the same cycle run_idle falls.
- R9: While mode_stog is high, every pin_en is 1 whatever the enable control latch holds. diff_en is also 1, except as given by R11.
- R10: With the balance latch at 1, a selected pair that is toggling drives diff_p = tog_clk and diff_n = not tog_clk, with diff_en = 1.
- R11: With the balance latch at 0, a selected pair that is toggling keeps diff_p at its latch value and diff_n at the inverse, and drives diff_en = tog_clk.
- R12: With neither mode_extest nor mode_stog high, every pin_en and diff_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial data into chain position 0 |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| mode_extest | input | 1 | External-test instruction active |
| mode_stog | input | 1 | Selective-toggle instruction active |
| run_idle | input | 1 | Controller is in Run-Test/Idle |
| tog_clk | input | 1 | Divided toggle waveform, synchronous to tck |
| pin_in | input | N_PINS | Observed levels of the single-ended pins |
| diff_in | input | N_DIFF | Observed levels of the differential pairs |
| scan_out | output | 1 | Serial data out of the last chain position |
| pin_data | output | N_PINS | Data to the single-ended pad drivers |
| pin_en | output | N_PINS | Enables of the single-ended pad drivers |
| diff_p | output | N_DIFF | True leg data of each pair |
| diff_n | output | N_DIFF | Complement leg data of each pair |
| diff_en | output | N_DIFF | Enable of each pair driver |

## Verification
The bench pulses update_dr right after shifting a selection pattern under selective toggle. If the design let that pulse through, the hold levels would be overwritten by the selection bits, and the unselected pins would drive the wrong values afterwards. It drops run_idle in the middle of toggling and expects the hold levels in that same cycle; a design that registered the revert would keep toggling for one extra cycle. It runs the pairs in both balanced and unbalanced mode. Swapping those branches would toggle the data in place of the enable, and forcing the enable under toggle would override a cleared enable latch; both show up as wrong diff_p, diff_n and diff_en values sampled on every cycle.

// File: rtl/stog_pkg.sv
package stog_pkg;

   // Drive regime of the output cells, decoded once at the top.
   typedef enum logic [1:0] {
      MD_FUNC      = 2'd0,
      MD_EXTEST    = 2'd1,
      MD_STOG_HOLD = 2'd2,
      MD_STOG_RUN  = 2'd3
   } drv_mode_e;

   function automatic drv_mode_e decode_mode(input logic extest, input logic stog,
                                             input logic idle);
      if (stog)        return idle ? MD_STOG_RUN : MD_STOG_HOLD;
      else if (extest) return MD_EXTEST;
      else             return MD_FUNC;
   endfunction

endpackage

// File: rtl/stog_cell.sv
module stog_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shift_en,
   input  logic upd_en,
   input  logic cap_val,
   input  logic si,
   output logic so,
   output logic hold
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        so <= 1'b0;
      else if (cap_en)   so <= cap_val;
      else if (shift_en) so <= si;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold <= 1'b0;
      else if (upd_en) hold <= so;
   end

   // R3: capture wins over shift
   a_r3_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> (so == $past(cap_val)));

   // R2: one place per clock
   a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !cap_en) |=> (so == $past(si)));

   // R5: latch only moves on an update
   a_r5_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(hold));

endmodule

// File: rtl/stog_se_drive.sv
module stog_se_drive
   import stog_pkg::*;
#(
   parameter int N_PINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  drv_mode_e         mode,
   input  logic [N_PINS-1:0] sel,
   input  logic [N_PINS-1:0] hold,
   input  logic              ext_en,
   input  logic              tog,
   output logic [N_PINS-1:0] data,
   output logic [N_PINS-1:0] en
);

   localparam logic [N_PINS-1:0] ALL_ON = '1;

   always_comb begin
      data = hold;
      en   = '0;
      unique case (mode)
         MD_FUNC:      en = '0;
         MD_EXTEST:    en = {N_PINS{ext_en}};
         MD_STOG_HOLD: en = ALL_ON;
         MD_STOG_RUN: begin
            en   = ALL_ON;
            data = (sel & {N_PINS{tog}}) | (~sel & hold);
         end
         default:      en = '0;
      endcase
   end

   // R7: unselected pins never move while their latches are steady
   a_r7_unselected_steady: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MD_STOG_RUN) && $stable(hold) && $stable(sel))
         |-> (((data ^ $past(data)) & ~sel) == '0));

endmodule

// File: rtl/stog_diff_drive.sv
module stog_diff_drive
   import stog_pkg::*;
#(
   parameter int N_DIFF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  drv_mode_e         mode,
   input  logic [N_DIFF-1:0] sel,
   input  logic [N_DIFF-1:0] hold,
   input  logic              ext_en,
   input  logic              bal,
   input  logic              tog,
   output logic [N_DIFF-1:0] p,
   output logic [N_DIFF-1:0] n,
   output logic [N_DIFF-1:0] en
);

   always_comb begin
      p  = hold;
      n  = ~hold;
      en = '0;
      for (int i = 0; i < N_DIFF; i++) begin
         unique case (mode)
            MD_FUNC:      en[i] = 1'b0;
            MD_EXTEST:    en[i] = ext_en;
            MD_STOG_HOLD: en[i] = 1'b1;
            MD_STOG_RUN: begin
               en[i] = 1'b1;
               if (sel[i]) begin
                  if (bal) begin
                     p[i] = tog;
                     n[i] = ~tog;
                  end else begin
                     en[i] = tog;
                  end
               end
            end
            default:      en[i] = 1'b0;
         endcase
      end
   end

   // R11: unbalanced toggling leaves the leg data fixed
   a_r11_unbal_data_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MD_STOG_RUN) && ($past(mode) == MD_STOG_RUN) && !bal && $stable(bal)
         && $stable(hold) && $stable(sel)) |-> (((p ^ $past(p)) & sel) == '0));

endmodule

// File: rtl/stog_bscan_chain.sv
module stog_bscan_chain
   import stog_pkg::*;
#(
   parameter int N_PINS = 8,
   parameter int N_DIFF = 2
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              scan_in,
   input  logic              capture_dr,
   input  logic              shift_dr,
   input  logic              update_dr,
   input  logic              mode_extest,
   input  logic              mode_stog,
   input  logic              run_idle,
   input  logic              tog_clk,
   input  logic [N_PINS-1:0] pin_in,
   input  logic [N_DIFF-1:0] diff_in,
   output logic              scan_out,
   output logic [N_PINS-1:0] pin_data,
   output logic [N_PINS-1:0] pin_en,
   output logic [N_DIFF-1:0] diff_p,
   output logic [N_DIFF-1:0] diff_n,
   output logic [N_DIFF-1:0] diff_en
);

   localparam int CHAIN     = N_PINS + N_DIFF + 2;
   localparam int EN_IDX    = 0;
   localparam int PIN_BASE  = 1;
   localparam int DIFF_BASE = PIN_BASE + N_PINS;
   localparam int BAL_IDX   = CHAIN - 1;

   if (N_PINS < 1) begin : g_chk_pins
      $error("stog_bscan_chain: N_PINS must be at least 1");
   end
   if (N_DIFF < 1) begin : g_chk_diff
      $error("stog_bscan_chain: N_DIFF must be at least 1");
   end

   logic [CHAIN-1:0] sh;
   logic [CHAIN-1:0] hd;
   logic             upd_ok;
   drv_mode_e        mode;

   // The update pulse is withheld under selective toggle so hold levels survive.
   assign upd_ok = update_dr & ~mode_stog;
   assign mode   = decode_mode(mode_extest, mode_stog, run_idle);

   for (genvar k = 0; k < CHAIN; k++) begin : g_cell
      logic si_k;
      logic cap_k;
      if (k == 0) begin : g_first
         assign si_k = scan_in;
      end else begin : g_next
         assign si_k = sh[k-1];
      end
      if (k == EN_IDX || k == BAL_IDX) begin : g_ctl
         assign cap_k = hd[k];
      end else if (k < DIFF_BASE) begin : g_pin
         assign cap_k = pin_in[k-PIN_BASE];
      end else begin : g_pair
         assign cap_k = diff_in[k-DIFF_BASE];
      end
      stog_cell u_cell (
         .clk      (tck),
         .rst_n    (rst_n),
         .cap_en   (capture_dr),
         .shift_en (shift_dr),
         .upd_en   (upd_ok),
         .cap_val  (cap_k),
         .si       (si_k),
         .so       (sh[k]),
         .hold     (hd[k])
      );
   end

   assign scan_out = sh[BAL_IDX];

   stog_se_drive #(.N_PINS(N_PINS)) u_se (
      .clk    (tck),
      .rst_n  (rst_n),
      .mode   (mode),
      .sel    (sh[PIN_BASE +: N_PINS]),
      .hold   (hd[PIN_BASE +: N_PINS]),
      .ext_en (hd[EN_IDX]),
      .tog    (tog_clk),
      .data   (pin_data),
      .en     (pin_en)
   );

   stog_diff_drive #(.N_DIFF(N_DIFF)) u_diff (
      .clk    (tck),
      .rst_n  (rst_n),
      .mode   (mode),
      .sel    (sh[DIFF_BASE +: N_DIFF]),
      .hold   (hd[DIFF_BASE +: N_DIFF]),
      .ext_en (hd[EN_IDX]),
      .bal    (hd[BAL_IDX]),
      .tog    (tog_clk),
      .p      (diff_p),
      .n      (diff_n),
      .en     (diff_en)
   );

   // R5: update strobe has no effect under selective toggle
   a_r5_update_blocked: assert property (@(posedge tck) disable iff (!rst_n)
      (mode_stog && update_dr) |=> $stable(hd));

   // R9: every single-ended pin drives under selective toggle
   a_r9_all_drive: assert property (@(posedge tck) disable iff (!rst_n)
      mode_stog |-> (&pin_en));

   // R8: outside Run-Test/Idle the pins show their hold levels
   a_r8_revert_hold: assert property (@(posedge tck) disable iff (!rst_n)
      (mode_stog && !run_idle) |-> (pin_data == hd[PIN_BASE +: N_PINS]));

   // R12: no test instruction, no drive
   a_r12_released: assert property (@(posedge tck) disable iff (!rst_n)
      (!mode_stog && !mode_extest) |-> ((pin_en == '0) && (diff_en == '0)));

endmodule

// File: tb/stog_bscan_chain_test.sv
module stog_bscan_chain_test;

   localparam int NP = 8;
   localparam int ND = 2;
   localparam int L  = NP + ND + 2;
   localparam int DB = 1 + NP;

   logic          tck = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_in = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic          mode_extest = 1'b0, mode_stog = 1'b0, run_idle = 1'b0, tog_clk = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic [ND-1:0] diff_in = '0;
   logic          scan_out;
   logic [NP-1:0] pin_data, pin_en;
   logic [ND-1:0] diff_p, diff_n, diff_en;

   always #2.5 tck = ~tck;

   stog_bscan_chain uut (
      .tck(tck), .rst_n(rst_n), .scan_in(scan_in), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .update_dr(update_dr), .mode_extest(mode_extest),
      .mode_stog(mode_stog), .run_idle(run_idle), .tog_clk(tog_clk),
      .pin_in(pin_in), .diff_in(diff_in), .scan_out(scan_out),
      .pin_data(pin_data), .pin_en(pin_en), .diff_p(diff_p), .diff_n(diff_n),
      .diff_en(diff_en)
   );

   typedef struct {
      logic [NP-1:0] pd;
      logic [NP-1:0] pe;
      logic [ND-1:0] dp;
      logic [ND-1:0] dn;
      logic [ND-1:0] de;
      logic          so;
      string         tag;
   } exp_t;

   exp_t     sb_q[$];
   int       n_checks = 0;
   int       n_fails  = 0;
   logic [L-1:0] m_sh = '0;
   logic [L-1:0] m_up = '0;

   // Expected outputs from the requirement rules and the bench's own chain model.
   function automatic exp_t predict(input logic ext, input logic st, input logic ri,
                                    input logic tg, input string tag);
      exp_t e;
      e.tag = tag;
      e.so  = m_sh[L-1];
      for (int i = 0; i < NP; i++) begin
         e.pd[i] = (st && ri && m_sh[1+i]) ? tg : m_up[1+i];
         e.pe[i] = st ? 1'b1 : (ext ? m_up[0] : 1'b0);
      end
      for (int j = 0; j < ND; j++) begin
         e.dp[j] = m_up[DB+j];
         e.dn[j] = ~m_up[DB+j];
         e.de[j] = st ? 1'b1 : (ext ? m_up[0] : 1'b0);
         if (st && ri && m_sh[DB+j]) begin
            if (m_up[L-1]) begin
               e.dp[j] = tg;
               e.dn[j] = ~tg;
            end else begin
               e.de[j] = tg;
            end
         end
      end
      return e;
   endfunction

   task automatic step(input logic si, input logic cap, input logic sft, input logic upd,
                       input logic ext, input logic st, input logic ri, input logic tg,
                       input string tag);
      logic [L-1:0] nsh;
      @(posedge tck);
      #1;
      scan_in = si; capture_dr = cap; shift_dr = sft; update_dr = upd;
      mode_extest = ext; mode_stog = st; run_idle = ri; tog_clk = tg;
      sb_q.push_back(predict(ext, st, ri, tg, tag));
      nsh = m_sh;
      if (cap) begin
         nsh[0]   = m_up[0];
         nsh[L-1] = m_up[L-1];
         for (int i = 0; i < NP; i++) nsh[1+i]  = pin_in[i];
         for (int j = 0; j < ND; j++) nsh[DB+j] = diff_in[j];
      end else if (sft) begin
         nsh = {m_sh[L-2:0], si};
      end
      if (upd && !st) m_up = m_sh;
      m_sh = nsh;
   endtask

   task automatic shift_vec(input logic [L-1:0] v, input logic ext, input logic st,
                            input string tag);
      for (int k = L - 1; k >= 0; k--) step(v[k], 1'b0, 1'b1, 1'b0, ext, st, 1'b0, 1'b0, tag);
   endtask

   // Monitor: pop one expectation per cycle and compare at the falling edge.
   always @(negedge tck) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_checks++;
         if ({pin_data, pin_en, diff_p, diff_n, diff_en, scan_out} !==
             {e.pd, e.pe, e.dp, e.dn, e.de, e.so}) begin
            n_fails++;
            $display("FAIL %s: got pd=%b pe=%b dp=%b dn=%b de=%b so=%b exp pd=%b pe=%b dp=%b dn=%b de=%b so=%b",
                     e.tag, pin_data, pin_en, diff_p, diff_n, diff_en, scan_out,
                     e.pd, e.pe, e.dp, e.dn, e.de, e.so);
         end
      end
   end

   initial begin
      #(200000 * 5);
      n_fails++;
      $display("FAIL watchdog: got no completion exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   // Hold pattern: enable cell 1, pins 8'b1010_0110, pairs 2'b10, balance 1.
   localparam logic [L-1:0] HOLD_A = {1'b1, 2'b10, 8'b1010_0110, 1'b1};
   // Hold pattern: enable cell 0, balance 0, same pin and pair levels.
   localparam logic [L-1:0] HOLD_B = {1'b0, 2'b10, 8'b1010_0110, 1'b0};
   // Selection: pins 2 and 5, pair 0, plus a 1 in the enable control cell.
   localparam logic [L-1:0] SEL    = {1'b0, 2'b01, 8'b0010_0100, 1'b1};

   initial begin
      repeat (3) @(posedge tck);
      @(negedge tck);
      n_checks++;
      // R1 reset state
      if ({pin_data, pin_en, diff_p, diff_n, diff_en, scan_out} !== {8'h00, 8'h00, 2'b00, 2'b11, 2'b00, 1'b0}) begin
         n_fails++;
         $display("FAIL R1: got pd=%b pe=%b dp=%b dn=%b de=%b so=%b exp all zero with dn=11",
                  pin_data, pin_en, diff_p, diff_n, diff_en, scan_out);
      end
      @(posedge tck);
      #1 rst_n = 1'b1;
      step(0, 0, 0, 0, 0, 0, 0, 0, "R1 R12");

      // R2 R4: preload under external test, then update
      shift_vec(HOLD_A, 1'b1, 1'b0, "R2");
      step(0, 0, 0, 1, 1, 0, 0, 0, "R4");
      for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 1, 0, 0, k[0], "R6");

      // R3: capture observed pin levels and shift them out
      pin_in  = 8'h3C;
      diff_in = 2'b01;
      step(0, 1, 0, 0, 1, 0, 0, 0, "R3");
      for (int k = 0; k < L; k++) step(k[0], 0, 1, 0, 1, 0, 0, 0, "R3");

      // R5 R9: selection under selective toggle, update pulse withheld
      shift_vec(SEL, 1'b0, 1'b1, "R9");
      step(0, 0, 0, 1, 0, 1, 0, 0, "R5");
      step(0, 0, 0, 0, 0, 1, 0, 1, "R5 R8");

      // R7 R10: toggling in Run-Test/Idle, balanced pairs
      for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 1, 1, k[0], "R7 R10");
      step(0, 0, 0, 0, 0, 1, 0, 1, "R8");
      step(0, 0, 0, 0, 0, 1, 0, 0, "R8");

      // R6 R11: reload hold levels with balance 0 and enable 0, then toggle
      shift_vec(HOLD_B, 1'b1, 1'b0, "R2");
      step(0, 0, 0, 1, 1, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 1, 0, 0, 1, "R6");
      shift_vec(SEL, 1'b0, 1'b1, "R9");
      step(0, 0, 0, 1, 0, 1, 0, 0, "R5");
      for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 1, 1, k[0], "R7 R11");
      step(0, 0, 0, 0, 0, 1, 0, 1, "R8");

      // R12: no test instruction releases every driver
      for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 1, k[0], "R12");

      @(posedge tck);
      @(posedge tck);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule